// File: doc/BRIEF.md
# Buffered Synchronous Serial Port

This block is a clocked serial channel that moves a whole block of bytes between a local byte buffer and four serial lines: shift clock, serial data out, serial data in and an active-low chip select. Software, or a surrounding controller, fills the buffer through a simple host port, sets a byte count and a mode, and pulses `start`. The block then shifts every byte without further help and raises `done` when the count is used up.

As master, the block drives the shift clock from a divider and asserts its own chip select for the whole block. As slave, it follows an external shift clock that counts only while the external chip select is low. All external inputs are resynchronised. Clock edges are masked for a short window after chip select falls and during a fixed busy gap after every byte. The buffer is used either as one shared area, where each received byte overwrites the byte just sent, or split into a transmit half and a receive half.

Top module: `sio_block_port`

## Requirements
- R1: After reset `done`=0, `busy`=0, `sck_o`=1, `cs_n_o`=1, `sck_oe`=0 and `sdo_oe`=0.
- R2: With `split_mode`=0, a start with count N sends buffer bytes 0..N-1 in that order and writes each received byte back at the index it was sent from. Afterwards `busy` is 0 and `done` is 1.
- R3: With `split_mode`=1, byte k is sent from index k and the byte received in the same slot is stored at index 64+k (half the buffer depth). Indices 0..63 stay unchanged.
- R4: The count is limited to 128 in shared mode and to 64 in split mode. A count of 0 sets `done` one cycle after start and produces no shift clock edge.
- R5: As master, bytes go out MSB first. `sdo` changes only together with a falling edge of `sck_o`, and `sdi` is taken at the rising edge. Every high and every low phase of `sck_o` lasts at least 4 clocks. `cs_n_o` is 0 and `sck_oe` is 1 while busy.
- R6: As slave, `sck_i`, `cs_n_i` and `sdi` pass through a two-flop synchroniser. Shift clock edges that reach the core in the cycle chip select is seen falling, or in the 3 clocks after it, are ignored.
- R7: As slave, after each byte the port waits 6 clocks, ignoring clock edges, before it loads the next transmit byte.
- R8: As slave, clock edges while `cs_n_i` is high are ignored. `sdo_oe` is 1 only while busy with `cs_n_i` low, and `sck_oe` stays 0.
- R9: `start` clears `done`, and `done` then stays 0 until the programmed count has been transferred.
- R10: The host port writes a buffer byte when `host_we` is 1 and reads the byte at `host_addr` combinationally on `host_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a block |
| xfer_len | input | 8 | Byte count for the block |
| slave_mode | input | 1 | 1: external shift clock, 0: internal |
| split_mode | input | 1 | 1: separate transmit and receive halves |
| busy | output | 1 | Block in progress |
| done | output | 1 | Count exhausted; cleared by start |
| host_we | input | 1 | Host buffer write enable |
| host_addr | input | 7 | Host buffer index |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte |
| sck_o | output | 1 | Shift clock driven as master (idles high) |
| sck_oe | output | 1 | Drive enable for the shift clock pad |
| sck_i | input | 1 | External shift clock as slave |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Drive enable for the data out pad |
| sdi | input | 1 | Serial data in |
| cs_n_o | output | 1 | Chip select driven as master |
| cs_n_i | input | 1 | Chip select received as slave |

## Verification
Master results appear on the ports one clock after the divider decides: `sck_o` and the new `sdo` bit change together, and `done` rises 4 clocks after the last rising shift edge. The bench samples them on the falling clock edge after each change. Slave results lag the pins by the two synchroniser flops plus the edge-detect register, which is about 3 clocks. The bench therefore holds each shift clock phase for 6 clocks and reads `sdo` just before it raises the clock. It places deliberate glitches inside the 3-clock mask window and the 6-clock gap, so that a port that counts them corrupts the data it compares. Buffer contents are read back through the host port only after `done`.

// File: rtl/sio_pkg.sv
package sio_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_MLO,
        ST_MHI,
        ST_SRUN,
        ST_SGAP
    } sio_state_e;
endpackage

// File: rtl/sio_sync.sv
module sio_sync #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            hold_q <= RST_VAL;
        end else begin
            meta_q <= d;
            hold_q <= meta_q;
        end
    end

    assign q = hold_q;
endmodule

// File: rtl/sio_buf_ram.sv
module sio_buf_ram #(
    parameter int DEPTH = 128,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          core_we,
    input  logic [AW-1:0] core_waddr,
    input  logic [DW-1:0] core_wdata,
    input  logic [AW-1:0] core_raddr,
    output logic [DW-1:0] core_rdata,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (core_we) begin
            mem[core_waddr] <= core_wdata;
        end else if (host_we) begin
            mem[host_addr] <= host_wdata;
        end
    end

    assign core_rdata = mem[core_raddr];
    assign host_rdata = mem[host_addr];
endmodule

// File: rtl/sio_xfer_core.sv
module sio_xfer_core
    import sio_pkg::*;
#(
    parameter int DEPTH    = 128,
    parameter int HALF_DIV = 4,
    parameter int MASK_CYC = 3,
    parameter int GAP_CYC  = 6,
    localparam int AW = $clog2(DEPTH),
    localparam int LW = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LW-1:0]     xfer_len,
    input  logic              slave_mode,
    input  logic              split_mode,
    input  logic              sck_s,
    input  logic              cs_s,
    input  logic              sdi_s,
    input  logic              sdi_raw,
    output logic [AW-1:0]     rd_addr,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              sck_o,
    output logic              sdo,
    output logic              busy,
    output logic              done,
    output logic              slave_q
);
    localparam int DW = $clog2(HALF_DIV + 1);
    localparam int MW = $clog2(MASK_CYC + 1);
    localparam int GW = $clog2(GAP_CYC + 1);
    localparam int BCW = $clog2(BYTE_W + 1);
    localparam logic [LW-1:0]  FULL_LIM = LW'(DEPTH);
    localparam logic [LW-1:0]  HALF_LIM = LW'(DEPTH / 2);
    localparam logic [DW-1:0]  DIV_LAST = DW'(HALF_DIV - 1);
    localparam logic [GW-1:0]  GAP_LAST = GW'(GAP_CYC - 1);
    localparam logic [MW-1:0]  MASK_LD  = MW'(MASK_CYC);
    localparam logic [BCW-1:0] BITS     = BCW'(BYTE_W);

    typedef struct packed {
        sio_state_e        st;
        logic [AW-1:0]     idx;
        logic [LW-1:0]     cnt;
        logic [BCW-1:0]    bitc;
        logic [DW-1:0]     div;
        logic [GW-1:0]     gap;
        logic [MW-1:0]     mask;
        logic [BYTE_W-1:0] tx;
        logic [BYTE_W-1:0] rx;
        logic              sck;
        logic              done;
        logic              sck_prev;
        logic              cs_prev;
        logic              slave;
        logic              split;
    } core_t;

    core_t r_q, r_d;

    logic              fall, rise, cs_fall, edge_ok, byte_end;
    logic [LW-1:0]     lim, len_eff;
    logic [BYTE_W-1:0] rx_new;

    assign rd_addr = r_q.idx;
    assign wr_addr = r_q.split ? (r_q.idx + AW'(HALF_LIM)) : r_q.idx;

    always_comb begin
        r_d      = r_q;
        wr_en    = 1'b0;
        wr_data  = r_q.rx;
        byte_end = 1'b0;
        rx_new   = {r_q.rx[BYTE_W-2:0], sdi_s};

        fall    = r_q.sck_prev & ~sck_s;
        rise    = ~r_q.sck_prev & sck_s;
        cs_fall = r_q.cs_prev & ~cs_s;
        r_d.sck_prev = sck_s;
        r_d.cs_prev  = cs_s;

        if (cs_fall) begin
            r_d.mask = MASK_LD;
        end else if (r_q.mask != '0) begin
            r_d.mask = r_q.mask - 1'b1;
        end
        edge_ok = ~cs_s & ~cs_fall & (r_q.mask == '0);

        lim     = split_mode ? HALF_LIM : FULL_LIM;
        len_eff = (xfer_len > lim) ? lim : xfer_len;

        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.done  = 1'b0;
                    r_d.slave = slave_mode;
                    r_d.split = split_mode;
                    r_d.idx   = '0;
                    if (len_eff == '0) begin
                        r_d.done = 1'b1;
                    end else begin
                        r_d.cnt = len_eff;
                        r_d.st  = ST_LOAD;
                    end
                end
            end
            ST_LOAD: begin
                r_d.tx   = rd_data;
                r_d.rx   = '0;
                r_d.bitc = '0;
                r_d.div  = '0;
                if (r_q.slave) begin
                    r_d.st = ST_SRUN;
                end else begin
                    r_d.st  = ST_MLO;
                    r_d.sck = 1'b0;
                end
            end
            ST_MLO: begin
                if (r_q.div == DIV_LAST) begin
                    r_d.div  = '0;
                    r_d.sck  = 1'b1;
                    r_d.rx   = {r_q.rx[BYTE_W-2:0], sdi_raw};
                    r_d.bitc = r_q.bitc + 1'b1;
                    r_d.st   = ST_MHI;
                end else begin
                    r_d.div = r_q.div + 1'b1;
                end
            end
            ST_MHI: begin
                if (r_q.div == DIV_LAST) begin
                    r_d.div = '0;
                    if (r_q.bitc == BITS) begin
                        wr_en    = 1'b1;
                        byte_end = 1'b1;
                    end else begin
                        r_d.sck = 1'b0;
                        r_d.tx  = {r_q.tx[BYTE_W-2:0], 1'b0};
                        r_d.st  = ST_MLO;
                    end
                end else begin
                    r_d.div = r_q.div + 1'b1;
                end
            end
            ST_SRUN: begin
                if (edge_ok) begin
                    if (fall && r_q.bitc != '0) begin
                        r_d.tx = {r_q.tx[BYTE_W-2:0], 1'b0};
                    end
                    if (rise) begin
                        r_d.rx   = rx_new;
                        r_d.bitc = r_q.bitc + 1'b1;
                        if (r_q.bitc == BITS - 1'b1) begin
                            wr_en    = 1'b1;
                            wr_data  = rx_new;
                            byte_end = 1'b1;
                        end
                    end
                end
            end
            ST_SGAP: begin
                if (r_q.gap == '0) begin
                    r_d.st = ST_LOAD;
                end else begin
                    r_d.gap = r_q.gap - 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase

        if (byte_end) begin
            r_d.idx = r_q.idx + 1'b1;
            r_d.cnt = r_q.cnt - 1'b1;
            r_d.gap = GAP_LAST;
            if (r_q.cnt == LW'(1)) begin
                r_d.st   = ST_IDLE;
                r_d.done = 1'b1;
            end else begin
                r_d.st = r_q.slave ? ST_SGAP : ST_LOAD;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q          <= '0;
            r_q.st       <= ST_IDLE;
            r_q.sck      <= 1'b1;
            r_q.sck_prev <= 1'b1;
            r_q.cs_prev  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign sck_o   = r_q.sck;
    assign sdo     = r_q.tx[BYTE_W-1];
    assign busy    = (r_q.st != ST_IDLE);
    assign done    = r_q.done;
    assign slave_q = r_q.slave;

    // checker state: length of the current shift clock phase and of the gap
    logic [DW:0] ph_q;
    logic        sck_seen_q;
    logic [GW:0] gap_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q       <= (DW+1)'(HALF_DIV);
            sck_seen_q <= 1'b1;
            gap_seen_q <= '0;
        end else begin
            sck_seen_q <= r_q.sck;
            if (r_q.sck != sck_seen_q) begin
                ph_q <= (DW+1)'(1);
            end else if (ph_q < (DW+1)'(HALF_DIV)) begin
                ph_q <= ph_q + 1'b1;
            end
            gap_seen_q <= (r_q.st == ST_SGAP) ? gap_seen_q + 1'b1 : '0;
        end
    end

    a_r5_min_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_q.slave && r_q.sck != sck_seen_q) |-> (ph_q >= (DW+1)'(HALF_DIV)));

    a_r6_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_SRUN && r_q.mask != '0) |=> (r_q.bitc == $past(r_q.bitc)));

    a_r7_gap_len: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(r_q.st) == ST_SGAP && r_q.st == ST_LOAD) |-> (gap_seen_q == (GW+1)'(GAP_CYC)));

    a_r8_cs_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_SRUN && cs_s) |=> (r_q.bitc == $past(r_q.bitc)));

    a_r9_done_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.done) |-> ($past(wr_en) || $past(start)));

    a_r3_split_idx: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.split && busy) |-> (r_q.idx <= AW'(HALF_LIM)));
endmodule

// File: rtl/sio_block_port.sv
module sio_block_port
    import sio_pkg::*;
#(
    parameter int DEPTH    = 128,
    parameter int HALF_DIV = 4,
    parameter int MASK_CYC = 3,
    parameter int GAP_CYC  = 6,
    localparam int AW = $clog2(DEPTH),
    localparam int LW = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LW-1:0]     xfer_len,
    input  logic              slave_mode,
    input  logic              split_mode,
    output logic              busy,
    output logic              done,
    input  logic              host_we,
    input  logic [AW-1:0]     host_addr,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    output logic              sck_o,
    output logic              sck_oe,
    input  logic              sck_i,
    output logic              sdo,
    output logic              sdo_oe,
    input  logic              sdi,
    output logic              cs_n_o,
    input  logic              cs_n_i
);
    logic [2:0]        pins_s;
    logic              sck_s, cs_s, sdi_s;
    logic [AW-1:0]     rd_addr, wr_addr;
    logic [BYTE_W-1:0] rd_data, wr_data;
    logic              wr_en, slave_q, master_on;

    sio_sync #(.W(3), .RST_VAL(3'b110)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sck_i, cs_n_i, sdi}),
        .q     (pins_s)
    );
    assign {sck_s, cs_s, sdi_s} = pins_s;

    sio_buf_ram #(.DEPTH(DEPTH), .DW(BYTE_W)) u_ram (
        .clk        (clk),
        .core_we    (wr_en),
        .core_waddr (wr_addr),
        .core_wdata (wr_data),
        .core_raddr (rd_addr),
        .core_rdata (rd_data),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata)
    );

    sio_xfer_core #(
        .DEPTH    (DEPTH),
        .HALF_DIV (HALF_DIV),
        .MASK_CYC (MASK_CYC),
        .GAP_CYC  (GAP_CYC)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .xfer_len   (xfer_len),
        .slave_mode (slave_mode),
        .split_mode (split_mode),
        .sck_s      (sck_s),
        .cs_s       (cs_s),
        .sdi_s      (sdi_s),
        .sdi_raw    (sdi),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .sck_o      (sck_o),
        .sdo        (sdo),
        .busy       (busy),
        .done       (done),
        .slave_q    (slave_q)
    );

    assign master_on = busy & ~slave_q;
    assign sck_oe    = master_on;
    assign cs_n_o    = ~master_on;
    assign sdo_oe    = busy & (slave_q ? ~cs_s : 1'b1);

    a_r8_slave_no_sck_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && slave_q) |-> !sck_oe);
endmodule

// File: tb/tb_sio_block_port.sv
module tb_sio_block_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] xfer_len = '0;
    logic       slave_mode = 1'b0;
    logic       split_mode = 1'b0;
    logic       busy, done;
    logic       host_we = 1'b0;
    logic [6:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       sck_o, sck_oe, sdo, sdo_oe, cs_n_o;
    logic       sck_i = 1'b1;
    logic       cs_n_i = 1'b1;
    logic       sdi_drv = 1'b0;
    logic       sdi_w;

    int total = 0;
    int bad = 0;

    logic [7:0] model [128];
    logic [7:0] txs [128];
    logic [7:0] rxp [128];

    always #2 clk = ~clk;

    assign sdi_w = slave_mode ? sdi_drv : ~sdo;

    sio_block_port dut (
        .clk(clk), .rst_n(rst_n), .start(start), .xfer_len(xfer_len),
        .slave_mode(slave_mode), .split_mode(split_mode), .busy(busy), .done(done),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .sck_o(sck_o), .sck_oe(sck_oe), .sck_i(sck_i),
        .sdo(sdo), .sdo_oe(sdo_oe), .sdi(sdi_w), .cs_n_o(cs_n_o), .cs_n_i(cs_n_i)
    );

    function automatic int eff_len(int len, bit split);
        int lim = split ? 64 : 128;
        return (len > lim) ? lim : len;
    endfunction

    function automatic int rx_index(int k, bit split);
        return split ? 64 + k : k;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_wr(int a, logic [7:0] d);
        @(negedge clk);
        host_we = 1'b1;
        host_addr = 7'(a);
        host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic preload();
        for (int i = 0; i < 128; i++) begin
            model[i] = 8'($urandom);
            host_wr(i, model[i]);
        end
    endtask

    task automatic compare_buffer(string req);
        int miss = 0;
        int first = -1;
        for (int i = 0; i < 128; i++) begin
            host_addr = 7'(i);
            #1;
            if (host_rdata !== model[i]) begin
                miss++;
                if (first < 0) first = i;
            end
        end
        chk(miss == 0, req, miss, 0);
        if (first >= 0) $display("  first mismatch at index %0d", first);
    endtask

    task automatic pulse_start(int len, bit slv, bit split);
        @(negedge clk);
        slave_mode = slv;
        split_mode = split;
        xfer_len = 8'(len);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_master(int len, bit split);
        int n = eff_len(len, split);
        int falls = 0, bad_bits = 0, bad_ph = 0, bad_cs = 0, run = 100, cyc = 0;
        int k = 0, b = 0;
        logic prev = 1'b1;
        preload();
        for (int i = 0; i < n; i++) txs[i] = model[i];
        pulse_start(len, 1'b0, split);
        if (n > 0) chk(done == 1'b0, "R9 done cleared by start", done, 0);
        else chk(done == 1'b1, "R4 zero count done", done, 1);
        while (!done && cyc < 20000) begin
            if (busy && (cs_n_o !== 1'b0 || sck_oe !== 1'b1)) bad_cs++;
            @(negedge clk);
            cyc++;
            if (sck_o !== prev) begin
                if (run < 4) bad_ph++;
                run = 1;
                if (sck_o == 1'b1) begin
                    if (sdo !== txs[k][7-b]) bad_bits++;
                    b++;
                    if (b == 8) begin b = 0; k++; end
                end else begin
                    falls++;
                end
                prev = sck_o;
            end else begin
                run++;
            end
        end
        chk(falls == n * 8, "R4 shift edge count", falls, n * 8);
        chk(bad_bits == 0, "R5 MSB-first output bits", bad_bits, 0);
        chk(bad_ph == 0, "R5 phase at least 4 clocks", bad_ph, 0);
        chk(bad_cs == 0, "R5 cs_n_o low and sck_oe high while busy", bad_cs, 0);
        chk(done == 1'b1 && busy == 1'b0, "R2 block finished", {done, busy}, 2);
        for (int i = 0; i < n; i++) model[rx_index(i, split)] = ~txs[i];
        compare_buffer(split ? "R3 split buffer contents" : "R2 shared buffer contents");
    endtask

    task automatic run_slave(int len, bit split, bit gl);
        int n = eff_len(len, split);
        int bad_bits = 0, bad_oe = 0;
        preload();
        for (int i = 0; i < n; i++) begin
            txs[i] = model[i];
            rxp[i] = 8'($urandom);
        end
        pulse_start(len, 1'b1, split);
        repeat (4) @(negedge clk);
        if (gl) begin
            for (int g = 0; g < 3; g++) begin
                sck_i = 1'b0; repeat (2) @(negedge clk);
                sck_i = 1'b1; repeat (2) @(negedge clk);
            end
        end
        repeat (3) @(negedge clk);
        chk(sdo_oe == 1'b0, "R8 sdo released with cs high", sdo_oe, 0);
        chk(sck_oe == 1'b0, "R8 sck not driven as slave", sck_oe, 0);
        cs_n_i = 1'b0;
        if (gl) sck_i = 1'b0;
        @(negedge clk);
        sck_i = 1'b1;
        repeat (8) @(negedge clk);
        for (int k = 0; k < n; k++) begin
            for (int b = 0; b < 8; b++) begin
                sck_i = 1'b0;
                sdi_drv = rxp[k][7-b];
                repeat (6) @(negedge clk);
                if (sdo !== txs[k][7-b]) bad_bits++;
                if (sdo_oe !== 1'b1) bad_oe++;
                sck_i = 1'b1;
                @(negedge clk);
                if (b == 7) begin
                    if (gl) begin
                        sck_i = 1'b0;
                        @(negedge clk);
                        sck_i = 1'b1;
                    end
                    repeat (16) @(negedge clk);
                end else begin
                    repeat (5) @(negedge clk);
                end
            end
        end
        chk(bad_bits == 0, gl ? "R6 R7 slave bits with glitches" : "R6 slave output bits", bad_bits, 0);
        chk(bad_oe == 0, "R8 sdo driven while selected", bad_oe, 0);
        chk(done == 1'b1 && busy == 1'b0, "R2 slave block finished", {done, busy}, 2);
        cs_n_i = 1'b1;
        repeat (4) @(negedge clk);
        chk(sdo_oe == 1'b0, "R8 sdo released after cs rises", sdo_oe, 0);
        for (int i = 0; i < n; i++) model[rx_index(i, split)] = rxp[i];
        compare_buffer(gl ? "R7 slave buffer after gap glitch" : "R3 slave split buffer");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h51_0C_4A_11));
        repeat (3) @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R1 idle status", {done, busy}, 0);
        chk(sck_o == 1'b1 && cs_n_o == 1'b1, "R1 idle pins", {sck_o, cs_n_o}, 3);
        chk(sck_oe == 1'b0 && sdo_oe == 1'b0, "R1 released pads", {sck_oe, sdo_oe}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R10: host write then read back
        host_wr(5, 8'hA5);
        host_addr = 7'd5;
        #1;
        chk(host_rdata == 8'hA5, "R10 host port", host_rdata, 8'hA5);

        run_master(0, 1'b0);
        run_master(5, 1'b0);
        run_master(7, 1'b1);
        run_master(200, 1'b0);
        run_master(100, 1'b1);
        for (int t = 0; t < 4; t++) begin
            run_master(1 + int'($urandom % 20), 1'($urandom % 2));
        end

        run_slave(3, 1'b0, 1'b1);
        run_slave(4, 1'b1, 1'b0);
        run_slave(2, 1'b1, 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule